// File: doc/BRIEF.md
# Physical Layer Frame Segmenter

This block sits behind frame lock in a satellite demodulator and tags each incoming symbol of a physical-layer frame as header, data or pilot. It also reports which data slot the symbol belongs to and how many pilot fields have been reached. Downstream, these tags steer pilot symbols to the carrier, phase and gain loops and data symbols to the demapper. The symbol samples pass through with one register of latency, aligned with their tags.

A frame-start pulse, qualified by the symbol strobe, marks the first header symbol. On that symbol the block captures the frame size (normal or short), the bits per symbol and whether pilots are present. A small table built at elaboration supplies the number of data slots, the number of pilot fields and the total length. The block then walks the frame. A frame start that arrives while a frame is still being counted raises a length-error pulse, and the count restarts from the new header.

Top module: `plseg_frame_segmenter`

## Requirements
- R1: During and right after reset, `vld_o`, `cls_o`, `len_err_o`, `slot_o`, `pil_o` and `len_o` are all zero.
- R2: A symbol with `vld_i` and `sof_i` both high starts a frame. It and the next 89 valid symbols are tagged header (`cls_o` = 2'b01), with `slot_o` = 0 and `pil_o` = 0.
- R3: The number of data slots S is 360, 240, 180 and 144 for normal frames (`frm_short_i` = 0) and 90, 60, 45 and 36 for short frames, for 2, 3, 4 and 5 bits per symbol. The last data slot carries `slot_o` = S-1.
- R4: After the header come S data slots of 90 symbols each, tagged data (`cls_o` = 2'b10), with `slot_o` counting 0 to S-1 and `pil_o` equal to the number of pilot fields already passed.
- R5: With `pil_en_i` = 1, a 36-symbol pilot field (`cls_o` = 2'b11) follows every 16th data slot. During the field, `slot_o` holds the preceding slot and `pil_o` holds the field's own index, counted from 0.
- R6: No pilot field follows the last data slot, so a frame holds floor((S-1)/16) pilot fields when pilots are on and none when they are off.
- R7: `len_o` shows 90*(S+1) + 36*P for the current frame from its first header symbol on (for example, 33282 for a normal frame with 2 bits per symbol and pilots). After exactly that many valid symbols, further valid symbols without a frame start are tagged idle (`cls_o` = 2'b00) with `slot_o` = 0 and `pil_o` = 0.
- R8: A frame start that arrives before the current frame has been fully counted drives `len_err_o` high for exactly the output cycle of that start symbol, and the count restarts as a new header. A frame start that arrives right after the last symbol of a frame gives no error.
- R9: The frame-size, bits-per-symbol and pilot inputs are captured only with a frame start. Changes to them during a frame have no effect on tags, indices or `len_o`.
- R10: `sym_o` and `vld_o` equal `sym_i` and `vld_i` one clock earlier. When `vld_o` is low, `cls_o` is idle. Cycles without `vld_i` do not advance the frame count.
- R11: A bits-per-symbol value below 2 is treated as 2, and a value above 5 is treated as 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_i | input | 1 | Frame start, marks the first header symbol when `vld_i` is high |
| vld_i | input | 1 | Symbol strobe |
| frm_short_i | input | 1 | 1 = short frame, 0 = normal frame |
| bps_i | input | 3 | Bits per symbol (2 to 5) |
| pil_en_i | input | 1 | Pilot fields present |
| sym_i | input | 32 | Complex symbol, I and Q of 16 bits each |
| sym_o | output | 32 | Symbol delayed by one clock |
| vld_o | output | 1 | Strobe delayed by one clock |
| cls_o | output | 2 | Symbol class: 00 idle, 01 header, 10 data, 11 pilot |
| slot_o | output | 9 | Data slot index |
| pil_o | output | 5 | Pilot field index |
| len_o | output | 16 | Total length of the current frame in symbols |
| len_err_o | output | 1 | One-cycle pulse on an early frame start |

## Verification
The bench builds the block with its default geometry: 64800- and 16200-bit codewords, 90-symbol slots, 36-symbol pilot fields placed every 16 slots, and 16-bit I and Q. These values bring within reach the longest frame (33282 symbols), a slot count that is an exact multiple of 16 (normal frame at 5 bits per symbol), where a trailing pilot field must be left out, and short frames whose pilot count rounds down. Because the widths are derived from these values, the top of every index and the length counter are reached at full scale.

// File: rtl/plseg_pkg.sv
// Shared types for the frame segmenter.
// Holds the class encoding seen at the ports and the clamp that maps
// bits per symbol onto a row of the geometry table.
package plseg_pkg;

    typedef enum logic [1:0] {
        CLS_IDLE = 2'b00,
        CLS_HDR  = 2'b01,
        CLS_DATA = 2'b10,
        CLS_PIL  = 2'b11
    } sym_cls_e;

    // Map bits per symbol onto table row 0..3, saturating out-of-range values.
    function automatic logic [1:0] order_row(input logic [2:0] bps);
        if (bps <= 3'd2)
            return 2'd0;
        else if (bps >= 3'd5)
            return 2'd3;
        else
            return 2'(bps - 3'd2);
    endfunction

endpackage

// File: rtl/plseg_geom.sv
// Frame geometry capture.
// Builds, at elaboration, the slot count, pilot field count and total
// length for every (frame size, modulation order, pilots) combination,
// and registers the selected entry when load_i is high.
// Assumes that the normal codeword is the larger one and that each count
// fits the widths given by the parent.
module plseg_geom #(
    parameter int NRM_BITS   = 64800,
    parameter int SHT_BITS   = 16200,
    parameter int SLOT_SYMS  = 90,
    parameter int PIL_SYMS   = 36,
    parameter int PIL_PERIOD = 16,
    parameter int SLOT_W     = 9,
    parameter int PIL_W      = 5,
    parameter int LEN_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              short_i,
    input  logic [2:0]        bps_i,
    input  logic              pil_en_i,
    output logic [SLOT_W-1:0] slots_o,
    output logic [PIL_W-1:0]  pils_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              pil_en_o
);
    import plseg_pkg::*;

    localparam int N_TYPES  = 2;
    localparam int N_ORDERS = 4;
    localparam int ROWS     = N_TYPES * N_ORDERS;
    localparam int MIN_BPS  = 2;

    logic [SLOT_W-1:0] slot_tab [ROWS];
    logic [PIL_W-1:0]  pil_tab  [ROWS];
    logic [LEN_W-1:0]  lbare_tab[ROWS];
    logic [LEN_W-1:0]  lpil_tab [ROWS];

    // Constant table: one entry per frame size and modulation order.
    for (genvar ft = 0; ft < N_TYPES; ft++) begin : g_type
        for (genvar mo = 0; mo < N_ORDERS; mo++) begin : g_order
            localparam int BITS = (ft == 0) ? NRM_BITS : SHT_BITS;
            localparam int NS   = BITS / (SLOT_SYMS * (mo + MIN_BPS));
            localparam int NP   = (NS - 1) / PIL_PERIOD;
            assign slot_tab[ft*N_ORDERS+mo]  = SLOT_W'(NS);
            assign pil_tab[ft*N_ORDERS+mo]   = PIL_W'(NP);
            assign lbare_tab[ft*N_ORDERS+mo] = LEN_W'(SLOT_SYMS * (NS + 1));
            assign lpil_tab[ft*N_ORDERS+mo]  = LEN_W'(SLOT_SYMS * (NS + 1) + PIL_SYMS * NP);
        end
    end

    logic [2:0] row;
    assign row = {short_i, order_row(bps_i)};

    // Capture the geometry of the frame that starts this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_o  <= '0;
            pils_o   <= '0;
            len_o    <= '0;
            pil_en_o <= 1'b0;
        end else if (load_i) begin
            slots_o  <= slot_tab[row];
            pils_o   <= pil_en_i ? pil_tab[row] : '0;
            len_o    <= pil_en_i ? lpil_tab[row] : lbare_tab[row];
            pil_en_o <= pil_en_i;
        end
    end

    // Geometry is frozen between frame starts.
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(slots_o) && $stable(len_o) && $stable(pils_o) && $stable(pil_en_o)));

    // Slot and pilot tables agree with the length table.
    p_len_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slots_o != '0) |-> (int'(len_o) == SLOT_SYMS * (int'(slots_o) + 1) + PIL_SYMS * int'(pils_o)));

    // Never as many pilot fields as full 16-slot groups ending the frame.
    p_pil_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slots_o != '0) |-> (int'(pils_o) * PIL_PERIOD <= int'(slots_o) - 1));

endmodule

// File: rtl/plseg_walk.sv
// Frame walker.
// Steps through header, data slots and pilot fields one valid symbol at a
// time and presents the class and indices of the symbol now on the input.
// Assumes slots_i and pil_en_i hold the geometry captured at the last
// frame start and that PIL_SYMS does not exceed SLOT_SYMS.
module plseg_walk #(
    parameter int SLOT_SYMS  = 90,
    parameter int PIL_SYMS   = 36,
    parameter int PIL_PERIOD = 16,
    parameter int SLOT_W     = 9,
    parameter int PIL_W      = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic                sof_i,
    input  logic [SLOT_W-1:0]   slots_i,
    input  logic                pil_en_i,
    output plseg_pkg::sym_cls_e cls_o,
    output logic [SLOT_W-1:0]   slot_o,
    output logic [PIL_W-1:0]    pil_o,
    output logic                busy_o
);
    import plseg_pkg::*;

    localparam int POS_W = $clog2(SLOT_SYMS);
    localparam int GRP_W = $clog2(PIL_PERIOD + 1);
    localparam logic [POS_W-1:0] SLOT_LAST = POS_W'(SLOT_SYMS - 1);
    localparam logic [POS_W-1:0] PIL_LAST  = POS_W'(PIL_SYMS - 1);
    localparam logic [GRP_W-1:0] GRP_LAST  = GRP_W'(PIL_PERIOD - 1);

    sym_cls_e          kind_q, b_kind, n_kind;
    logic [POS_W-1:0]  pos_q,  b_pos,  n_pos;
    logic [SLOT_W-1:0] slot_q, b_slot, n_slot;
    logic [GRP_W-1:0]  grp_q,  b_grp,  n_grp;
    logic [PIL_W-1:0]  pil_q,  b_pil,  n_pil;
    logic              start;

    assign start = vld_i && sof_i;

    // Position of the symbol on the input: a frame start overrides the state.
    always_comb begin
        if (start) begin
            b_kind = CLS_HDR;
            b_pos  = '0;
            b_slot = '0;
            b_grp  = '0;
            b_pil  = '0;
        end else begin
            b_kind = kind_q;
            b_pos  = pos_q;
            b_slot = slot_q;
            b_grp  = grp_q;
            b_pil  = pil_q;
        end
    end

    assign cls_o  = b_kind;
    assign slot_o = b_slot;
    assign pil_o  = b_pil;
    assign busy_o = (kind_q != CLS_IDLE);

    // Advance by one symbol on each strobe; the last slot never opens a pilot field.
    always_comb begin
        n_kind = kind_q;
        n_pos  = pos_q;
        n_slot = slot_q;
        n_grp  = grp_q;
        n_pil  = pil_q;
        if (vld_i) begin
            n_kind = b_kind;
            n_pos  = b_pos + POS_W'(1);
            n_slot = b_slot;
            n_grp  = b_grp;
            n_pil  = b_pil;
            unique case (b_kind)
                CLS_HDR: begin
                    if (b_pos == SLOT_LAST) begin
                        n_kind = CLS_DATA;
                        n_pos  = '0;
                    end
                end
                CLS_DATA: begin
                    if (b_pos == SLOT_LAST) begin
                        n_pos = '0;
                        if (b_slot == slots_i - SLOT_W'(1)) begin
                            n_kind = CLS_IDLE;
                            n_slot = '0;
                            n_grp  = '0;
                            n_pil  = '0;
                        end else if (pil_en_i && (b_grp == GRP_LAST)) begin
                            n_kind = CLS_PIL;
                            n_grp  = '0;
                        end else begin
                            n_slot = b_slot + SLOT_W'(1);
                            n_grp  = (b_grp == GRP_LAST) ? '0 : b_grp + GRP_W'(1);
                        end
                    end
                end
                CLS_PIL: begin
                    if (b_pos == PIL_LAST) begin
                        n_kind = CLS_DATA;
                        n_pos  = '0;
                        n_slot = b_slot + SLOT_W'(1);
                        n_pil  = b_pil + PIL_W'(1);
                    end
                end
                default: begin
                    n_kind = CLS_IDLE;
                    n_pos  = '0;
                end
            endcase
        end
    end

    // Walker state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= CLS_IDLE;
            pos_q  <= '0;
            slot_q <= '0;
            grp_q  <= '0;
            pil_q  <= '0;
        end else begin
            kind_q <= n_kind;
            pos_q  <= n_pos;
            slot_q <= n_slot;
            grp_q  <= n_grp;
            pil_q  <= n_pil;
        end
    end

    // Data slot index stays inside the captured slot count.
    p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == CLS_DATA) |-> (slot_q < slots_i));

    // Pilot fields exist only when pilots were captured as enabled.
    p_pil_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == CLS_PIL) |-> (pil_en_i && (pos_q < POS_W'(PIL_SYMS))));

    // A pilot field never follows the final data slot.
    p_no_tail_pil_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == CLS_PIL) |-> (slot_q < slots_i - SLOT_W'(1)));

    // Leaving a pilot field moves to the next slot and the next field index.
    p_pil_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !sof_i && kind_q == CLS_PIL && pos_q == PIL_LAST)
        |=> (kind_q == CLS_DATA && pil_q == $past(pil_q) + PIL_W'(1) && slot_q == $past(slot_q) + SLOT_W'(1)));

    // Without a strobe the walk does not move.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(kind_q) && $stable(pos_q) && $stable(slot_q)));

endmodule

// File: rtl/plseg_frame_segmenter.sv
// Physical layer frame segmenter, top level.
// Captures frame geometry on a frame start, walks the frame and registers
// the symbol, its class, slot and pilot-field indices and an early-start
// error, all one clock behind the input strobe.
// Assumes a frame start is only meaningful together with the symbol strobe.
module plseg_frame_segmenter #(
    parameter int DATA_W     = 16,
    parameter int NRM_BITS   = 64800,
    parameter int SHT_BITS   = 16200,
    parameter int SLOT_SYMS  = 90,
    parameter int PIL_SYMS   = 36,
    parameter int PIL_PERIOD = 16,
    localparam int S_MAX  = NRM_BITS / (SLOT_SYMS * 2),
    localparam int P_MAX  = (S_MAX - 1) / PIL_PERIOD,
    localparam int SLOT_W = $clog2(S_MAX + 1),
    localparam int PIL_W  = $clog2(P_MAX + 1),
    localparam int LEN_W  = $clog2(SLOT_SYMS * (S_MAX + 1) + PIL_SYMS * P_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof_i,
    input  logic                vld_i,
    input  logic                frm_short_i,
    input  logic [2:0]          bps_i,
    input  logic                pil_en_i,
    input  logic [2*DATA_W-1:0] sym_i,
    output logic [2*DATA_W-1:0] sym_o,
    output logic                vld_o,
    output logic [1:0]          cls_o,
    output logic [SLOT_W-1:0]   slot_o,
    output logic [PIL_W-1:0]    pil_o,
    output logic [LEN_W-1:0]    len_o,
    output logic                len_err_o
);
    import plseg_pkg::*;

    logic              start;
    logic [SLOT_W-1:0] cfg_slots;
    logic [PIL_W-1:0]  cfg_pils;
    logic              cfg_pil_en;
    sym_cls_e          cur_cls;
    logic [SLOT_W-1:0] cur_slot;
    logic [PIL_W-1:0]  cur_pil;
    logic              busy;

    assign start = sof_i && vld_i;

    plseg_geom #(
        .NRM_BITS  (NRM_BITS),
        .SHT_BITS  (SHT_BITS),
        .SLOT_SYMS (SLOT_SYMS),
        .PIL_SYMS  (PIL_SYMS),
        .PIL_PERIOD(PIL_PERIOD),
        .SLOT_W    (SLOT_W),
        .PIL_W     (PIL_W),
        .LEN_W     (LEN_W)
    ) u_geom (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start),
        .short_i (frm_short_i),
        .bps_i   (bps_i),
        .pil_en_i(pil_en_i),
        .slots_o (cfg_slots),
        .pils_o  (cfg_pils),
        .len_o   (len_o),
        .pil_en_o(cfg_pil_en)
    );

    plseg_walk #(
        .SLOT_SYMS (SLOT_SYMS),
        .PIL_SYMS  (PIL_SYMS),
        .PIL_PERIOD(PIL_PERIOD),
        .SLOT_W    (SLOT_W),
        .PIL_W     (PIL_W)
    ) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (vld_i),
        .sof_i   (sof_i),
        .slots_i (cfg_slots),
        .pil_en_i(cfg_pil_en),
        .cls_o   (cur_cls),
        .slot_o  (cur_slot),
        .pil_o   (cur_pil),
        .busy_o  (busy)
    );

    // Output stage: symbol, tags and early-start error for each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_o     <= '0;
            vld_o     <= 1'b0;
            cls_o     <= CLS_IDLE;
            slot_o    <= '0;
            pil_o     <= '0;
            len_err_o <= 1'b0;
        end else begin
            sym_o     <= sym_i;
            vld_o     <= vld_i;
            cls_o     <= vld_i ? cur_cls : CLS_IDLE;
            len_err_o <= start && busy;
            if (vld_i) begin
                slot_o <= cur_slot;
                pil_o  <= cur_pil;
            end
        end
    end

    // Frame symbol tally kept only for the checks below.
    logic             hdr0_q;
    logic [LEN_W:0]   seen_q;

    // Track frame starts and count frame symbols at the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr0_q <= 1'b0;
            seen_q <= '0;
        end else begin
            hdr0_q <= start;
            if (vld_o) begin
                if (hdr0_q)
                    seen_q <= (LEN_W+1)'(1);
                else if (cls_o != CLS_IDLE)
                    seen_q <= seen_q + (LEN_W+1)'(1);
            end
        end
    end

    // A frame ends exactly at its computed length.
    p_len_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && cls_o == CLS_IDLE) |-> (seen_q == '0 || seen_q == {1'b0, len_o}));

    // No frame symbol beyond the computed length.
    p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && cls_o != CLS_IDLE && !hdr0_q) |-> (seen_q < {1'b0, len_o}));

    // Error pulses only on the first header symbol of a restarted frame.
    p_err_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> (vld_o && hdr0_q && cls_o == CLS_HDR));

    // First symbol after a frame start is a header at index zero.
    p_first_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr0_q |-> (cls_o == CLS_HDR && slot_o == '0 && pil_o == '0));

    // No class is reported without a strobe.
    p_idle_novld_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> (cls_o == CLS_IDLE));

endmodule

// File: tb/plseg_frame_segmenter_bench.sv
// Scoreboard bench: driver tasks queue the expected tags of each symbol,
// a monitor pops and compares them as the outputs appear.
module plseg_frame_segmenter_bench;

    typedef struct packed {
        logic        err;
        logic [1:0]  cls;
        logic [8:0]  slot;
        logic [4:0]  pil;
        logic [15:0] len;
        logic [31:0] sym;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_i = 1'b0;
    logic        vld_i = 1'b0;
    logic        frm_short_i = 1'b0;
    logic [2:0]  bps_i = 3'd2;
    logic        pil_en_i = 1'b0;
    logic [31:0] sym_i = '0;
    logic [31:0] sym_o;
    logic        vld_o;
    logic [1:0]  cls_o;
    logic [8:0]  slot_o;
    logic [4:0]  pil_o;
    logic [15:0] len_o;
    logic        len_err_o;

    int          checks = 0;
    int          errors = 0;
    int          remain = 0;
    bit          done = 1'b0;
    bit          mon_on = 1'b0;
    logic [15:0] cur_len = '0;
    logic [31:0] sym_ctr = 32'h1234_5678;
    item_t       exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    plseg_frame_segmenter u_plseg_frame_segmenter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .vld_i      (vld_i),
        .frm_short_i(frm_short_i),
        .bps_i      (bps_i),
        .pil_en_i   (pil_en_i),
        .sym_i      (sym_i),
        .sym_o      (sym_o),
        .vld_o      (vld_o),
        .cls_o      (cls_o),
        .slot_o     (slot_o),
        .pil_o      (pil_o),
        .len_o      (len_o),
        .len_err_o  (len_err_o)
    );

    function automatic int n_slots(input logic sh, input logic [2:0] b);
        int k;
        k = (b < 3'd2) ? 2 : ((b > 3'd5) ? 5 : int'(b));
        return (sh ? 16200 : 64800) / (90 * k);
    endfunction

    task automatic put(input logic s, input logic sh, input logic [2:0] b,
                       input logic pe, input logic v);
        @(negedge clk);
        sof_i       = s;
        frm_short_i = sh;
        bps_i       = b;
        pil_en_i    = pe;
        vld_i       = v;
        sym_i       = sym_ctr;
        sym_ctr     = sym_ctr + 32'h9e37_79b1;
    endtask

    task automatic push(input item_t it, input string tg);
        exp_q.push_back(it);
        tag_q.push_back(tg);
    endtask

    task automatic send_idle(input int n, input string tg);
        for (int i = 0; i < n; i++) begin
            item_t it;
            put(1'b0, 1'b0, 3'd2, 1'b0, 1'b1);
            it.err = 1'b0; it.cls = 2'b00; it.slot = '0; it.pil = '0;
            it.len = cur_len; it.sym = sym_i;
            push(it, tg);
        end
    endtask

    task automatic send_frame(input logic sh, input logic [2:0] b, input logic pe,
                              input int limit, input bit wig, input bit gap,
                              input string ovr);
        int   s_n, p_n, l_n, n_end, per;
        logic err;
        s_n   = n_slots(sh, b);
        p_n   = pe ? (s_n - 1) / 16 : 0;
        l_n   = 90 * (s_n + 1) + 36 * p_n;
        err   = (remain > 0);
        cur_len = 16'(l_n);
        n_end = (limit < l_n) ? limit : l_n;
        per   = 16 * 90 + 36;
        for (int n = 0; n < n_end; n++) begin
            item_t it;
            string tg;
            int    m, g, r;
            if (gap && (n % 5 == 4)) put(1'b0, sh, b, pe, 1'b0);
            if (n == 0)   put(1'b1, sh, b, pe, 1'b1);
            else if (wig) put(1'b0, ~sh, ~b, ~pe, 1'b1);
            else          put(1'b0, sh, b, pe, 1'b1);
            it.err = (n == 0) ? err : 1'b0;
            it.len = cur_len;
            it.sym = sym_i;
            if (n < 90) begin
                it.cls = 2'b01; it.slot = '0; it.pil = '0;
                tg = (n == 0) ? "R8" : "R2";
            end else begin
                m = n - 90;
                g = pe ? m / per : 0;
                r = pe ? m % per : m;
                if (r < 16 * 90 || !pe) begin
                    it.cls  = 2'b10;
                    it.slot = 9'(pe ? g * 16 + r / 90 : m / 90);
                    it.pil  = 5'(g);
                    tg = (int'(it.slot) == s_n - 1) ? "R3" : "R4";
                end else begin
                    it.cls  = 2'b11;
                    it.slot = 9'(g * 16 + 15);
                    it.pil  = 5'(g);
                    tg = (g == p_n - 1) ? "R6" : "R5";
                end
            end
            if (n > 0 && ovr != "") tg = ovr;
            push(it, tg);
        end
        remain = l_n - n_end;
    endtask

    // Monitor: compare every output symbol with the head of the queue.
    always @(negedge clk) begin
        if (mon_on) begin
            checks++;
            if (vld_o) begin
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R10 output symbol with nothing expected: cls=%0d slot=%0d", cls_o, slot_o);
                end else begin
                    item_t e, a;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    a  = {len_err_o, cls_o, slot_o, pil_o, len_o, sym_o};
                    if (a !== e) begin
                        errors++;
                        $display("FAIL %s err/cls/slot/pil/len/sym actual %0d/%0d/%0d/%0d/%0d/%h expected %0d/%0d/%0d/%0d/%0d/%h",
                                 tg, a.err, a.cls, a.slot, a.pil, a.len, a.sym,
                                 e.err, e.cls, e.slot, e.pil, e.len, e.sym);
                    end
                end
            end else if (cls_o !== 2'b00 || len_err_o !== 1'b0) begin
                errors++;
                $display("FAIL R10 no strobe but cls=%0d err=%0d expected 0/0", cls_o, len_err_o);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, queue holds %0d", exp_q.size());
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (vld_o !== 1'b0 || cls_o !== 2'b00 || len_err_o !== 1'b0 ||
            len_o !== 16'd0 || slot_o !== 9'd0 || pil_o !== 5'd0) begin
            errors++;
            $display("FAIL R1 reset outputs vld/cls/err/len/slot/pil actual %0d/%0d/%0d/%0d/%0d/%0d expected all 0",
                     vld_o, cls_o, len_err_o, len_o, slot_o, pil_o);
        end
        rst_n  = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        send_idle(3, "R10");
        // Longest frame, then a back-to-back frame with strobe gaps (R10, R8 no error).
        send_frame(1'b0, 3'd2, 1'b1, 1 << 30, 1'b0, 1'b0, "");
        send_frame(1'b1, 3'd3, 1'b1, 1 << 30, 1'b0, 1'b1, "");
        // 144 slots: exact multiple of 16, no trailing pilot field (R6).
        send_frame(1'b0, 3'd5, 1'b1, 1 << 30, 1'b0, 1'b0, "");
        send_idle(4, "R7");
        // Configuration toggled inside the frame (R9).
        send_frame(1'b1, 3'd4, 1'b0, 1 << 30, 1'b1, 1'b0, "R9");
        // Out-of-range orders saturate (R11).
        send_frame(1'b1, 3'd7, 1'b0, 1 << 30, 1'b0, 1'b0, "R11");
        send_frame(1'b1, 3'd0, 1'b1, 1 << 30, 1'b0, 1'b0, "R11");
        // Early restarts (R8).
        send_frame(1'b1, 3'd3, 1'b1, 1000, 1'b0, 1'b0, "");
        send_frame(1'b1, 3'd2, 1'b1, 1 << 30, 1'b0, 1'b0, "");
        send_frame(1'b1, 3'd5, 1'b1, 50, 1'b0, 1'b0, "");
        send_frame(1'b1, 3'd5, 1'b1, 1 << 30, 1'b0, 1'b0, "");
        send_idle(3, "R7");
        put(1'b0, 1'b0, 3'd2, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 symbols missing at output: actual %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule